// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Controller

This block is the interrupt source logic of a two-channel serial controller. Each channel has three sources: receive, transmit and external/status. Conditions from the serial datapath arrive as single-cycle pulses and as modem-pin levels. Each channel's mode word decides which conditions latch a pending bit. The pending bits of both channels sit in one combined register at fixed positions.

A single interrupt request goes out when the master enable is set and a pending source is not masked by a source already in service. An acknowledge pulse marks the highest requesting source as in service. A command write later releases it. An optional vector output names the source being requested.

Software reaches the block through one register write port. The target channel is chosen by `wr_chan` (0 = channel A, 1 = channel B). The address picks a command word (0), the interrupt mode word (1), the shared master control word (9) or the status-edge enable mask (15).

Top module: `sic_irq_ctrl`

## Requirements
- R1: After reset the pending register, the interrupt request, the vector and both status snapshots are all zero.
- R2: With receive mode 2'b10 (mode word bits 4:3), every `rx_char` pulse sets the channel's receive pending bit. A `rx_read` pulse clears a pending bit that was set by a plain character.
- R3: With receive mode 2'b01, only the first character after reset or after command code 3'b100 (command word bits 5:3) sets receive pending. Later characters are ignored until that command re-arms the channel.
- R4: With receive mode 2'b11, characters without a special condition set nothing. With mode 2'b00, no receive condition sets anything, special conditions included.
- R5: A character is a special condition if it carries overrun (`rx_err` bit 0), framing (bit 1) or end of frame (bit 2). Parity (bit 3) counts only when mode word bit 2 is set. A special condition holds receive pending through `rx_read` until command code 3'b110 clears it.
- R6: A `tx_empty` pulse sets transmit pending only when mode word bit 1 is set. Command code 3'b101 clears it.
- R7: When mode word bit 0 is set, a rising or falling edge on any status input enabled in the mask word sets status pending. The mask bits are 7, 6, 5, 4, 3 and 1. Edges on inputs that are not enabled set nothing.
- R8: While status pending is set, the channel's status snapshot stays frozen. Command code 3'b010 clears status pending, and the snapshot follows its inputs again from the next cycle.
- R9: The pending register holds A receive at bit 5, A transmit at bit 4, A status at bit 3, B receive at bit 2, B transmit at bit 1 and B status at bit 0. Bits 7:6 read zero.
- R10: `irq_o` is high only when master control bit 3 is set and some pending bit is not blocked by an in-service bit of equal or higher position.
- R11: An `intack` pulse while `irq_o` is high puts the highest unblocked pending source in service. Lower sources are then blocked and higher ones are not. Command code 3'b111 on either channel releases the highest in-service source.
- R12: When `irq_o` is high, `vec_o` is the bit position (0 to 5) of the highest unblocked pending source. Otherwise it is zero.
- R13: A master control write with bits 7:6 = 2'b10 resets channel A, and 2'b01 resets channel B. A reset clears that channel's mode word, mask word, pending and in-service bits, and the master enable takes bit 3 of the same write. The value 2'b11 resets both channels and clears the master enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_chan | input | 1 | Target channel, 0 = A, 1 = B |
| wr_addr | input | ADDR_W | Register address (0 command, 1 mode, 9 master, 15 mask) |
| wr_data | input | DATA_W | Write data |
| rx_char | input | 2 | Received-character pulse, bit 0 = A |
| rx_err | input | 8 | Error flags with the character, 4 bits per channel, A in 3:0 |
| rx_read | input | 2 | Host read of receive data, bit 0 = A |
| tx_empty | input | 2 | Transmit buffer emptied pulse, bit 0 = A |
| stat_in | input | 16 | Status pin levels, 8 per channel, A in 7:0 |
| intack | input | 1 | Interrupt acknowledge pulse |
| pend_o | output | DATA_W | Combined pending register |
| irq_o | output | 1 | Interrupt request |
| vec_o | output | 3 | Position of the requesting source |
| stat_snap_o | output | 16 | Status snapshots, A in 7:0 |

## Verification
The assertions assume the receive, transmit and acknowledge inputs are one-cycle pulses sampled on the clock. They also assume the status levels are already synchronous to the clock and that error flags are only meaningful with a character pulse. The stimulus changes every input on the falling edge and drops each pulse one cycle later. It never raises a set condition and its clearing command or read in the same cycle. It moves status pins one at a time, so each edge is seen on its own.

// File: rtl/sic_pkg.sv
package sic_pkg;
   localparam int NCH        = 2;
   localparam int SRC_PER_CH = 3;
   localparam int NSRC       = NCH * SRC_PER_CH;
   localparam int VEC_W      = $clog2(NSRC);
   localparam int ERR_W      = 4;
   localparam int STAT_W     = 8;

   localparam int ERR_OVR = 0;
   localparam int ERR_FRM = 1;
   localparam int ERR_EOF = 2;
   localparam int ERR_PAR = 3;

   localparam int RA_CMD    = 0;
   localparam int RA_MODE   = 1;
   localparam int RA_MASTER = 9;
   localparam int RA_STEN   = 15;

   typedef enum logic [1:0] {
      RXM_OFF     = 2'b00,
      RXM_FIRST   = 2'b01,
      RXM_ALL     = 2'b10,
      RXM_SPECIAL = 2'b11
   } rx_mode_e;

   typedef enum logic [2:0] {
      CMD_NONE     = 3'b000,
      CMD_CLR_STAT = 3'b010,
      CMD_ARM_RX   = 3'b100,
      CMD_CLR_TX   = 3'b101,
      CMD_CLR_ERR  = 3'b110,
      CMD_CLR_IUS  = 3'b111
   } cmd_e;

   typedef struct packed {
      rx_mode_e rxm;
      logic     par_sc;
      logic     tx_ie;
      logic     st_ie;
   } mode_t;
endpackage

// File: rtl/sic_rx_src.sv
module sic_rx_src
   import sic_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chan_rst,
   input  mode_t            mode,
   input  logic             rx_char,
   input  logic [ERR_W-1:0] rx_err,
   input  logic             rx_read,
   input  logic             arm,
   input  logic             clr_err,
   output logic             rx_pend
);
   logic armed_q, char_q, sc_q;
   logic is_special, char_hit, sc_hit;

   always_comb begin
      is_special = rx_err[ERR_OVR] | rx_err[ERR_FRM] | rx_err[ERR_EOF]
                 | (rx_err[ERR_PAR] & mode.par_sc);
      sc_hit     = rx_char && is_special && (mode.rxm != RXM_OFF);
      unique case (mode.rxm)
         RXM_FIRST: char_hit = rx_char & armed_q;
         RXM_ALL:   char_hit = rx_char;
         default:   char_hit = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b1;
         char_q  <= 1'b0;
         sc_q    <= 1'b0;
      end else if (chan_rst) begin
         armed_q <= 1'b1;
         char_q  <= 1'b0;
         sc_q    <= 1'b0;
      end else begin
         if (char_hit)     char_q <= 1'b1;
         else if (rx_read) char_q <= 1'b0;
         if (sc_hit)       sc_q   <= 1'b1;
         else if (clr_err) sc_q   <= 1'b0;
         if (arm)          armed_q <= 1'b1;
         else if (rx_char && mode.rxm == RXM_FIRST) armed_q <= 1'b0;
      end
   end

   assign rx_pend = char_q | sc_q;
endmodule

// File: rtl/sic_stat_src.sv
module sic_stat_src
   import sic_pkg::*;
#(
   parameter logic [STAT_W-1:0] USED = 8'hFA
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chan_rst,
   input  logic              st_ie,
   input  logic [STAT_W-1:0] st_en,
   input  logic [STAT_W-1:0] stat_in,
   input  logic              clr_stat,
   output logic              st_pend,
   output logic [STAT_W-1:0] snap
);
   logic              pend_q;
   logic [STAT_W-1:0] snap_q;
   logic              edge_hit;

   assign edge_hit = st_ie && !pend_q && (|((stat_in ^ snap_q) & st_en & USED));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         snap_q <= '0;
      end else if (chan_rst) begin
         pend_q <= 1'b0;
         snap_q <= '0;
      end else begin
         if (!pend_q)       snap_q <= stat_in & USED;
         if (edge_hit)      pend_q <= 1'b1;
         else if (clr_stat) pend_q <= 1'b0;
      end
   end

   assign st_pend = pend_q;
   assign snap    = snap_q;
endmodule

// File: rtl/sic_prio.sv
module sic_prio
   import sic_pkg::*;
#(
   parameter bit VEC_STATUS = 1'b1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NSRC-1:0]  pend,
   input  logic             mie,
   input  logic             intack,
   input  logic             clr_ius,
   input  logic [NSRC-1:0]  ius_drop,
   output logic             irq,
   output logic [VEC_W-1:0] vec
);
   logic [NSRC-1:0]  ius_q, ius_n, blocked, act;
   logic [VEC_W-1:0] act_top, ius_top;
   logic             irq_w;

   always_comb begin
      act_top = '0;
      ius_top = '0;
      for (int i = 0; i < NSRC; i++) begin
         blocked[i] = |(ius_q >> i);
         act[i]     = pend[i] & ~blocked[i];
         if (act[i])   act_top = VEC_W'(i);
         if (ius_q[i]) ius_top = VEC_W'(i);
      end
      irq_w = mie & (|act);
      ius_n = ius_q;
      if (clr_ius && (|ius_q)) ius_n[ius_top] = 1'b0;
      if (intack && irq_w)     ius_n[act_top] = 1'b1;
      ius_n = ius_n & ~ius_drop;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ius_q <= '0;
      else        ius_q <= ius_n;
   end

   assign irq = irq_w;

   if (VEC_STATUS) begin : g_vec
      assign vec = irq_w ? act_top : '0;
   end else begin : g_novec
      assign vec = '0;
   end
endmodule

// File: rtl/sic_irq_ctrl.sv
module sic_irq_ctrl
   import sic_pkg::*;
#(
   parameter int                ADDR_W     = 4,
   parameter int                DATA_W     = 8,
   parameter bit                VEC_STATUS = 1'b1,
   parameter logic [STAT_W-1:0] STAT_USED  = 8'hFA
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic                    wr_chan,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [DATA_W-1:0]       wr_data,
   input  logic [NCH-1:0]          rx_char,
   input  logic [NCH*ERR_W-1:0]    rx_err,
   input  logic [NCH-1:0]          rx_read,
   input  logic [NCH-1:0]          tx_empty,
   input  logic [NCH*STAT_W-1:0]   stat_in,
   input  logic                    intack,
   output logic [DATA_W-1:0]       pend_o,
   output logic                    irq_o,
   output logic [VEC_W-1:0]        vec_o,
   output logic [NCH*STAT_W-1:0]   stat_snap_o
);
   if (DATA_W < 8) begin : g_bad_data
      $error("sic_irq_ctrl: DATA_W must be at least 8");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("sic_irq_ctrl: ADDR_W must be at least 4");
   end

   logic            wr_cmd, wr_mst, hard_rst, mie_q, clr_ius;
   cmd_e            cmd;
   logic [NCH-1:0]  chan_rst;
   logic [NSRC-1:0] src_pend, ius_drop;

   assign wr_cmd   = wr_en && (wr_addr == ADDR_W'(RA_CMD));
   assign wr_mst   = wr_en && (wr_addr == ADDR_W'(RA_MASTER));
   assign cmd      = cmd_e'(wr_data[5:3]);
   assign hard_rst = wr_mst && (wr_data[7:6] == 2'b11);
   assign chan_rst = wr_mst ? {wr_data[6], wr_data[7]} : '0;
   assign clr_ius  = wr_cmd && (cmd == CMD_CLR_IUS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mie_q <= 1'b0;
      else if (wr_mst) mie_q <= hard_rst ? 1'b0 : wr_data[3];
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      localparam int HI = NSRC - 1 - SRC_PER_CH * c;
      logic              sel, rx_p, tx_q, st_p;
      mode_t             mode_q;
      logic [STAT_W-1:0] sten_q;

      assign sel = (wr_chan == 1'(c));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mode_q <= '0;
            sten_q <= '0;
            tx_q   <= 1'b0;
         end else if (chan_rst[c]) begin
            mode_q <= '0;
            sten_q <= '0;
            tx_q   <= 1'b0;
         end else begin
            if (wr_en && sel && wr_addr == ADDR_W'(RA_MODE))
               mode_q <= mode_t'(wr_data[4:0]);
            if (wr_en && sel && wr_addr == ADDR_W'(RA_STEN))
               sten_q <= wr_data[STAT_W-1:0] & STAT_USED;
            if (tx_empty[c] && mode_q.tx_ie)
               tx_q <= 1'b1;
            else if (wr_cmd && sel && cmd == CMD_CLR_TX)
               tx_q <= 1'b0;
         end
      end

      sic_rx_src u_rx (
         .clk      (clk),
         .rst_n    (rst_n),
         .chan_rst (chan_rst[c]),
         .mode     (mode_q),
         .rx_char  (rx_char[c]),
         .rx_err   (rx_err[ERR_W*c +: ERR_W]),
         .rx_read  (rx_read[c]),
         .arm      (wr_cmd && sel && cmd == CMD_ARM_RX),
         .clr_err  (wr_cmd && sel && cmd == CMD_CLR_ERR),
         .rx_pend  (rx_p)
      );

      sic_stat_src #(.USED(STAT_USED)) u_st (
         .clk      (clk),
         .rst_n    (rst_n),
         .chan_rst (chan_rst[c]),
         .st_ie    (mode_q.st_ie),
         .st_en    (sten_q),
         .stat_in  (stat_in[STAT_W*c +: STAT_W]),
         .clr_stat (wr_cmd && sel && cmd == CMD_CLR_STAT),
         .st_pend  (st_p),
         .snap     (stat_snap_o[STAT_W*c +: STAT_W])
      );

      assign src_pend[HI -: SRC_PER_CH] = {rx_p, tx_q, st_p};
      assign ius_drop[HI -: SRC_PER_CH] = {SRC_PER_CH{chan_rst[c]}};
   end

   sic_prio #(.VEC_STATUS(VEC_STATUS)) u_prio (
      .clk      (clk),
      .rst_n    (rst_n),
      .pend     (src_pend),
      .mie      (mie_q),
      .intack   (intack),
      .clr_ius  (clr_ius),
      .ius_drop (ius_drop),
      .irq      (irq_o),
      .vec      (vec_o)
   );

   assign pend_o = DATA_W'(src_pend);
endmodule

// File: rtl/sic_irq_chk.sv
module sic_irq_chk
   import sic_pkg::*;
#(
   parameter int                DATA_W     = 8,
   parameter bit                VEC_STATUS = 1'b1,
   parameter logic [STAT_W-1:0] STAT_USED  = 8'hFA
)(
   input logic                  clk,
   input logic                  rst_n,
   input logic [NCH-1:0]        rx_char,
   input logic [NCH-1:0]        tx_empty,
   input logic [NCH*STAT_W-1:0] stat_in,
   input logic [DATA_W-1:0]     pend_o,
   input logic                  irq_o,
   input logic [VEC_W-1:0]      vec_o,
   input logic [NCH*STAT_W-1:0] stat_snap_o
);
   AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (pend_o != '0)); // R10

   AST_VEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_o |-> (vec_o == '0)); // R12

   AST_RX_CAUSE_A: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_o[5]) |-> $past(rx_char[0])); // R2

   AST_TX_CAUSE_B: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_o[1]) |-> $past(tx_empty[1])); // R6

   AST_ST_CAUSE_A: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_o[3]) |-> ((($past(stat_in[7:0]) ^ $past(stat_snap_o[7:0])) & STAT_USED) != '0)); // R7

   AST_SNAP_FROZEN_A: assert property (@(posedge clk) disable iff (!rst_n)
      pend_o[3] |=> $stable(stat_snap_o[7:0])); // R8

   AST_SNAP_FROZEN_B: assert property (@(posedge clk) disable iff (!rst_n)
      pend_o[0] |=> $stable(stat_snap_o[15:8])); // R8

   if (VEC_STATUS) begin : g_vec_chk
      AST_VEC_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
         irq_o |-> pend_o[vec_o]); // R11
   end
endmodule

bind sic_irq_ctrl sic_irq_chk #(
   .DATA_W     (DATA_W),
   .VEC_STATUS (VEC_STATUS),
   .STAT_USED  (STAT_USED)
) u_chk (.*);

// File: tb/tb_sic_irq_ctrl.sv
module tb_sic_irq_ctrl;
   import sic_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, wr_chan = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [1:0]  rx_char = '0, rx_read = '0, tx_empty = '0;
   logic [7:0]  rx_err = '0;
   logic [15:0] stat_in = '0;
   logic        intack = 1'b0;
   logic [7:0]  pend_o;
   logic        irq_o;
   logic [2:0]  vec_o;
   logic [15:0] stat_snap_o;

   always #2 clk = ~clk;

   sic_irq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan(wr_chan),
      .wr_addr(wr_addr), .wr_data(wr_data), .rx_char(rx_char),
      .rx_err(rx_err), .rx_read(rx_read), .tx_empty(tx_empty),
      .stat_in(stat_in), .intack(intack), .pend_o(pend_o),
      .irq_o(irq_o), .vec_o(vec_o), .stat_snap_o(stat_snap_o)
   );

   typedef struct {
      string       req;
      logic [7:0]  pend;
      logic        irq;
      logic [2:0]  vec;
      logic [15:0] snap;
   } exp_t;

   exp_t q[$];
   event sample_ev;
   int   checks = 0, fails = 0;
   bit   done = 1'b0;

   // scoreboard monitor: pops expected items at each sample point
   initial begin
      exp_t e;
      forever begin
         @(sample_ev);
         while (q.size() > 0) begin
            e = q.pop_front();
            checks++;
            if (pend_o !== e.pend || irq_o !== e.irq || vec_o !== e.vec || stat_snap_o !== e.snap) begin
               fails++;
               $display("FAIL %s: pend=%h irq=%b vec=%0d snap=%h, expected pend=%h irq=%b vec=%0d snap=%h",
                        e.req, pend_o, irq_o, vec_o, stat_snap_o, e.pend, e.irq, e.vec, e.snap);
            end
         end
      end
   end

   task automatic chk(input string req, input logic [7:0] p, input logic i,
                      input logic [2:0] v, input logic [15:0] s = 16'h0000);
      q.push_back('{req, p, i, v, s});
      -> sample_ev;
      #0;
   endtask

   task automatic wr(input int ch, input int a, input logic [7:0] d);
      wr_en = 1'b1; wr_chan = ch[0]; wr_addr = a[3:0]; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rx(input int ch, input logic [3:0] e);
      rx_char[ch] = 1'b1; rx_err[4*ch +: 4] = e;
      @(negedge clk);
      rx_char = '0; rx_err = '0;
   endtask

   task automatic rd(input int ch);
      rx_read[ch] = 1'b1; @(negedge clk); rx_read = '0;
   endtask

   task automatic txe(input int ch);
      tx_empty[ch] = 1'b1; @(negedge clk); tx_empty = '0;
   endtask

   task automatic ack();
      intack = 1'b1; @(negedge clk); intack = 1'b0;
   endtask

   task automatic setstat(input int ch, input logic [7:0] v);
      stat_in[8*ch +: 8] = v; @(negedge clk);
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset state", 8'h00, 1'b0, 3'd0, 16'h0000);

      wr(0, 9, 8'h08);
      chk("R10 master on, nothing pending", 8'h00, 1'b0, 3'd0);

      // R2 every-character mode on A
      wr(0, 1, 8'h10);
      rx(0, 4'b0000);
      chk("R2 char sets A rx", 8'h20, 1'b1, 3'd5);
      rd(0);
      chk("R2 read clears A rx", 8'h00, 1'b0, 3'd0);

      // R3 first-character mode
      wr(0, 1, 8'h08);
      rx(0, 4'b0000);
      chk("R3 first char", 8'h20, 1'b1, 3'd5);
      rd(0);
      rx(0, 4'b0000);
      chk("R3 second char ignored", 8'h00, 1'b0, 3'd0);
      wr(0, 0, 8'h20);
      rx(0, 4'b0000);
      chk("R3 re-armed char", 8'h20, 1'b1, 3'd5);
      rd(0);

      // R4 / R5 special-condition-only mode
      wr(0, 1, 8'h18);
      rx(0, 4'b0000);
      chk("R4 plain char ignored in special-only", 8'h00, 1'b0, 3'd0);
      rx(0, 4'b0010);
      chk("R5 framing error sets rx", 8'h20, 1'b1, 3'd5);
      rd(0);
      chk("R5 read keeps special condition", 8'h20, 1'b1, 3'd5);
      wr(0, 0, 8'h30);
      chk("R5 error reset clears", 8'h00, 1'b0, 3'd0);
      rx(0, 4'b1000);
      chk("R5 parity not special", 8'h00, 1'b0, 3'd0);
      wr(0, 1, 8'h1C);
      rx(0, 4'b1000);
      chk("R5 parity special when enabled", 8'h20, 1'b1, 3'd5);
      wr(0, 0, 8'h30);
      rx(0, 4'b0100);
      chk("R5 end of frame special", 8'h20, 1'b1, 3'd5);
      wr(0, 0, 8'h30);
      wr(0, 1, 8'h00);
      rx(0, 4'b0001);
      chk("R4 mode off ignores overrun", 8'h00, 1'b0, 3'd0);

      // R6 transmit
      wr(1, 1, 8'h02);
      txe(1);
      chk("R6 B tx pending", 8'h02, 1'b1, 3'd1);
      wr(1, 0, 8'h28);
      chk("R6 tx reset clears", 8'h00, 1'b0, 3'd0);
      txe(0);
      chk("R6 A tx disabled", 8'h00, 1'b0, 3'd0);

      // R9 layout of other positions
      wr(1, 1, 8'h10);
      rx(1, 4'b0000);
      chk("R9 B rx at bit 2", 8'h04, 1'b1, 3'd2);
      rd(1);
      wr(0, 1, 8'h02);
      txe(0);
      chk("R9 A tx at bit 4", 8'h10, 1'b1, 3'd4);
      wr(0, 0, 8'h28);

      // R7 / R8 status on B
      wr(1, 15, 8'h20);
      wr(1, 1, 8'h01);
      setstat(1, 8'h08);
      chk("R7 disabled pin ignored", 8'h00, 1'b0, 3'd0, 16'h0800);
      setstat(1, 8'h28);
      chk("R7 enabled rising edge", 8'h01, 1'b1, 3'd0, 16'h2800);
      setstat(1, 8'h20);
      chk("R8 snapshot frozen", 8'h01, 1'b1, 3'd0, 16'h2800);
      wr(1, 0, 8'h10);
      @(negedge clk);
      chk("R8 status reset resumes", 8'h00, 1'b0, 3'd0, 16'h2000);
      setstat(1, 8'h00);
      chk("R7 enabled falling edge", 8'h01, 1'b1, 3'd0, 16'h0000);
      wr(1, 0, 8'h10);
      chk("R8 status reset clears", 8'h00, 1'b0, 3'd0, 16'h0000);

      // R11 in-service nesting
      wr(0, 1, 8'h10);
      wr(1, 1, 8'h02);
      txe(1);
      chk("R11 B tx requests", 8'h02, 1'b1, 3'd1);
      ack();
      chk("R11 in service blocks itself", 8'h02, 1'b0, 3'd0);
      rx(0, 4'b0000);
      chk("R11 higher source nests", 8'h22, 1'b1, 3'd5);
      ack();
      chk("R11 both in service", 8'h22, 1'b0, 3'd0);
      wr(1, 0, 8'h38);
      chk("R11 release highest", 8'h22, 1'b1, 3'd5);
      rd(0);
      chk("R11 lower still blocked", 8'h02, 1'b0, 3'd0);
      wr(0, 0, 8'h38);
      chk("R11 release lower", 8'h02, 1'b1, 3'd1);

      // R10 master enable
      wr(0, 9, 8'h00);
      chk("R10 master off", 8'h02, 1'b0, 3'd0);
      wr(0, 9, 8'h08);
      chk("R10 master on", 8'h02, 1'b1, 3'd1);

      // R12 priority of vector, R13 resets
      rx(0, 4'b0000);
      chk("R12 highest source wins", 8'h22, 1'b1, 3'd5);
      wr(0, 9, 8'h48);
      chk("R13 B reset", 8'h20, 1'b1, 3'd5);
      txe(1);
      chk("R13 B tx enable cleared", 8'h20, 1'b1, 3'd5);
      wr(0, 9, 8'h88);
      chk("R13 A reset", 8'h00, 1'b0, 3'd0);
      wr(1, 1, 8'h02);
      txe(1);
      chk("R13 master kept by channel reset", 8'h02, 1'b1, 3'd1);
      wr(0, 9, 8'hC8);
      chk("R13 hard reset", 8'h00, 1'b0, 3'd0);
      wr(0, 9, 8'h08);
      txe(1);
      chk("R13 hard reset cleared modes", 8'h00, 1'b0, 3'd0);

      @(negedge clk);
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not complete, expected completion");
         summary();
         $finish;
      end
   end
endmodule